// File: doc/BRIEF.md
# Dual Divide-by-Two / Divide-by-Five Decade Counter

The block holds two independent counters. Each one is split into a one-bit section that divides by two and a three-bit section that divides by five. Each section has its own count-clock input, and it advances when that input goes from high to low. A free-running system clock samples every count-clock input through a short synchronizer. A falling edge found on the synchronized level advances the matching section by one. Each counter also has its own asynchronous clear, which forces all four of its outputs to zero at once and holds them there.

A per-counter chaining mode can link the two sections inside the block. In BCD chaining, the carry out of the divide-by-two stage drives the divide-by-five stage, so the counter steps through a decade count on its first count clock. In bi-quinary chaining, the carry out of the divide-by-five stage drives the divide-by-two stage, so the counter counts five, then five again, on its second count clock. With no chaining, the two sections run from their own inputs. The sections can then be linked outside the block, for example by feeding the top bit of one decade into the first count clock of the other counter to divide by 100.

The carries inside a counter take effect in the same system-clock cycle, so there is no ripple between sections. A carry that leaves the block and comes back in, as in the divide-by-100 chain, passes through the synchronizer of the receiving counter. It therefore arrives later.

Top module: `dual_decade_counter`

## Requirements
- R1: While ctr_rst[i] is high, counter i's nibble q_out[4i+3:4i] reads 0, with no wait for a system-clock edge, and no count-clock edge changes it. On release, the counter starts from 0.
- R2: In independent mode (chain_mode code 00, or the unused code 11), a falling edge on clk_a[i] toggles QA = q_out[4i]. A rising edge leaves QA unchanged.
- R3: In independent mode, a falling edge on clk_b[i] advances the three-bit value {QD,QC,QB} = q_out[4i+3:4i+1], with QB as its least significant bit. The value steps 0,1,2,3,4 and then wraps to 0. It never exceeds 4.
- R4: In BCD mode (chain_mode code 01), each falling edge of clk_a[i] steps the nibble {QD,QC,QB,QA} as a binary number through 0 to 9 and then back to 0. Edges on clk_b[i] are ignored.
- R5: In bi-quinary mode (chain_mode code 10), each falling edge of clk_b[i] steps the count 5*QA + {QD,QC,QB} through 0 to 9 and then back to 0. QA toggles exactly when {QD,QC,QB} wraps from 4 to 0. Edges on clk_a[i] are ignored.
- R6: A count-clock input that falls between two system-clock edges changes the outputs on the (SYNC_STAGES+1)-th rising system-clock edge after the fall. A section holds its value whenever no step reaches it.
- R7: Counter 1 is unaffected by the clear and the count clocks of counter 0. Two BCD counters, with QD of counter 0 feeding clk_a[1], together count 0 to 99 and wrap.
- R8: While rst_n is low, both counters and all synchronizers are cleared. With idle-high count clocks, no count is taken after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock that samples the count clocks |
| rst_n | input | 1 | Active-low asynchronous clear of the whole block |
| clk_a | input | NUM_CTR | Per-counter count clock of the divide-by-two section (falling edge) |
| clk_b | input | NUM_CTR | Per-counter count clock of the divide-by-five section (falling edge) |
| ctr_rst | input | NUM_CTR | Per-counter active-high asynchronous clear |
| chain_mode | input | 2*NUM_CTR | Per-counter chaining code: 00 independent, 01 BCD, 10 bi-quinary, 11 independent |
| q_out | output | 4*NUM_CTR | Per-counter nibble {QD,QC,QB,QA} |

## Verification
The hardest condition to reach from the ports is the tens counter stepping. That needs a carry which leaves counter 0 as a falling QD and comes back in through counter 1's synchronizer. The bench wires q_out[3] to clk_a[1] and clears both counters while the new wiring settles, so that the switch-over edge is not counted. It then applies 100 units pulses, each long enough for both synchronizer delays, and compares the pair of nibbles after every pulse. Clear timing is checked by raising ctr_rst between system-clock edges and sampling the outputs before the next edge. Latency is checked by sampling one edge before and one edge after the expected update.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
   typedef enum logic [1:0] {
      CHAIN_NONE  = 2'b00,
      CHAIN_BCD   = 2'b01,
      CHAIN_BIQUI = 2'b10,
      CHAIN_RSVD  = 2'b11
   } chain_mode_e;

   localparam int NIB_W   = 4;
   localparam int MOD_LO  = 2;
   localparam int MOD_HI  = 5;
endpackage

// File: rtl/ddc_edge_sync.sv
module ddc_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic fall
);
   initial begin
      assert (STAGES >= 2) else $fatal(1, "ddc_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[s] <= 1'b0;
               else        sync_q[s] <= sync_q[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sync_q[STAGES-1];
   end

   assign fall = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/ddc_modn.sv
module ddc_modn #(
   parameter int MODULUS = 5,
   localparam int W      = (MODULUS > 2) ? $clog2(MODULUS) : 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   output logic [W-1:0] count,
   output logic         at_last
);
   initial begin
      assert (MODULUS >= 2) else $fatal(1, "ddc_modn: MODULUS must be at least 2");
   end

   localparam logic [W-1:0] LAST = W'(MODULUS - 1);

   logic [W-1:0] cnt_q;

   generate
      if (MODULUS == 2) begin : g_toggle
         always_ff @(posedge clk or negedge rst_n or posedge clr) begin
            if (!rst_n)    cnt_q <= '0;
            else if (clr)  cnt_q <= '0;
            else if (step) cnt_q <= ~cnt_q;
         end
      end else begin : g_wrap
         always_ff @(posedge clk or negedge rst_n or posedge clr) begin
            if (!rst_n)    cnt_q <= '0;
            else if (clr)  cnt_q <= '0;
            else if (step) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         end
      end
   endgenerate

   assign count   = cnt_q;
   assign at_last = (cnt_q == LAST);
endmodule

// File: rtl/ddc_unit.sv
module ddc_unit
   import ddc_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             cka_in,
   input  logic             ckb_in,
   input  logic [1:0]       mode,
   output logic [NIB_W-1:0] q,
   output logic             step_a,
   output logic             step_b
);
   localparam int HI_W = $clog2(MOD_HI);

   logic            fall_a, fall_b;
   logic            last_a, last_b;
   logic [0:0]      cnt_a;
   logic [HI_W-1:0] cnt_b;
   logic            is_bcd, is_biq;

   ddc_edge_sync #(.STAGES(SYNC_STAGES)) sync_a_i (
      .clk (clk), .rst_n (rst_n), .din (cka_in), .fall (fall_a)
   );

   ddc_edge_sync #(.STAGES(SYNC_STAGES)) sync_b_i (
      .clk (clk), .rst_n (rst_n), .din (ckb_in), .fall (fall_b)
   );

   assign is_bcd = (mode == CHAIN_BCD);
   assign is_biq = (mode == CHAIN_BIQUI);

   // carries inside one counter act in the same system-clock cycle
   assign step_a = is_biq ? (fall_b & last_b) : fall_a;
   assign step_b = is_bcd ? (fall_a & last_a) : fall_b;

   ddc_modn #(.MODULUS(MOD_LO)) div2_i (
      .clk (clk), .rst_n (rst_n), .clr (clr), .step (step_a),
      .count (cnt_a), .at_last (last_a)
   );

   ddc_modn #(.MODULUS(MOD_HI)) div5_i (
      .clk (clk), .rst_n (rst_n), .clr (clr), .step (step_b),
      .count (cnt_b), .at_last (last_b)
   );

   assign q = {cnt_b, cnt_a};
endmodule

// File: rtl/dual_decade_counter.sv
module dual_decade_counter
   import ddc_pkg::*;
#(
   parameter int NUM_CTR     = 2,
   parameter int SYNC_STAGES = 2,
   localparam int Q_W        = NUM_CTR * NIB_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CTR-1:0]   clk_a,
   input  logic [NUM_CTR-1:0]   clk_b,
   input  logic [NUM_CTR-1:0]   ctr_rst,
   input  logic [2*NUM_CTR-1:0] chain_mode,
   output logic [Q_W-1:0]       q_out
);
   initial begin
      assert (NUM_CTR >= 1) else $fatal(1, "dual_decade_counter: NUM_CTR must be at least 1");
      assert (SYNC_STAGES >= 2) else $fatal(1, "dual_decade_counter: SYNC_STAGES must be at least 2");
   end

   logic [NUM_CTR-1:0] step_a;
   logic [NUM_CTR-1:0] step_b;

   genvar i;
   generate
      for (i = 0; i < NUM_CTR; i++) begin : g_ctr
         ddc_unit #(.SYNC_STAGES(SYNC_STAGES)) unit_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (ctr_rst[i]),
            .cka_in (clk_a[i]),
            .ckb_in (clk_b[i]),
            .mode   (chain_mode[2*i +: 2]),
            .q      (q_out[NIB_W*i +: NIB_W]),
            .step_a (step_a[i]),
            .step_b (step_b[i])
         );
      end
   endgenerate
endmodule

// File: rtl/ddc_checker.sv
module ddc_checker
   import ddc_pkg::*;
#(
   parameter int NUM_CTR = 2
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NUM_CTR-1:0]     ctr_rst,
   input logic [2*NUM_CTR-1:0]   chain_mode,
   input logic [4*NUM_CTR-1:0]   q_out,
   input logic [NUM_CTR-1:0]     step_a,
   input logic [NUM_CTR-1:0]     step_b
);
   genvar i;
   generate
      for (i = 0; i < NUM_CTR; i++) begin : g_chk
         assert_rst_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
            ctr_rst[i] |-> (q_out[4*i +: 4] == 4'd0));

         assert_qa_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctr_rst[i] && step_a[i]) |=> (q_out[4*i] != $past(q_out[4*i])));

         assert_div5_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (q_out[4*i+1 +: 3] <= 3'd4));

         assert_biq_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (chain_mode[2*i +: 2] == CHAIN_BIQUI && !ctr_rst[i] && step_b[i] && q_out[4*i+3])
            |=> (q_out[4*i] != $past(q_out[4*i])));

         assert_qa_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctr_rst[i] && !step_a[i]) |=> (ctr_rst[i] || $stable(q_out[4*i])));

         assert_div5_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctr_rst[i] && !step_b[i]) |=> (ctr_rst[i] || $stable(q_out[4*i+1 +: 3])));
      end
   endgenerate
endmodule

bind dual_decade_counter ddc_checker #(.NUM_CTR(NUM_CTR)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .ctr_rst    (ctr_rst),
   .chain_mode (chain_mode),
   .q_out      (q_out),
   .step_a     (step_a),
   .step_b     (step_b)
);

// File: tb/dual_decade_counter_tb_top.sv
`timescale 1ns/1ps
module dual_decade_counter_tb_top;
   localparam int N    = 2;
   localparam int SYNC = 2;
   localparam int NV   = 34;

   // row: [8] clear, [7:6] mode, [5] pulse clk_a, [4] pulse clk_b, [3:0] expected nibble
   localparam logic [8:0] VEC [NV] = '{
      {1'b1, 2'b01, 1'b0, 1'b0, 4'd0},
      {1'b0, 2'b01, 1'b1, 1'b0, 4'd1},
      {1'b0, 2'b01, 1'b1, 1'b0, 4'd2},
      {1'b0, 2'b01, 1'b1, 1'b0, 4'd3},
      {1'b0, 2'b01, 1'b1, 1'b0, 4'd4},
      {1'b0, 2'b01, 1'b1, 1'b0, 4'd5},
      {1'b0, 2'b01, 1'b1, 1'b0, 4'd6},
      {1'b0, 2'b01, 1'b1, 1'b0, 4'd7},
      {1'b0, 2'b01, 1'b1, 1'b0, 4'd8},
      {1'b0, 2'b01, 1'b1, 1'b0, 4'd9},
      {1'b0, 2'b01, 1'b1, 1'b0, 4'd0},
      {1'b0, 2'b01, 1'b0, 1'b1, 4'd0},
      {1'b0, 2'b01, 1'b1, 1'b0, 4'd1},
      {1'b1, 2'b10, 1'b0, 1'b0, 4'd0},
      {1'b0, 2'b10, 1'b0, 1'b1, 4'd2},
      {1'b0, 2'b10, 1'b0, 1'b1, 4'd4},
      {1'b0, 2'b10, 1'b0, 1'b1, 4'd6},
      {1'b0, 2'b10, 1'b0, 1'b1, 4'd8},
      {1'b0, 2'b10, 1'b0, 1'b1, 4'd1},
      {1'b0, 2'b10, 1'b0, 1'b1, 4'd3},
      {1'b0, 2'b10, 1'b0, 1'b1, 4'd5},
      {1'b0, 2'b10, 1'b0, 1'b1, 4'd7},
      {1'b0, 2'b10, 1'b0, 1'b1, 4'd9},
      {1'b0, 2'b10, 1'b0, 1'b1, 4'd0},
      {1'b0, 2'b10, 1'b1, 1'b0, 4'd0},
      {1'b1, 2'b00, 1'b0, 1'b0, 4'd0},
      {1'b0, 2'b00, 1'b1, 1'b0, 4'd1},
      {1'b0, 2'b00, 1'b1, 1'b0, 4'd0},
      {1'b0, 2'b00, 1'b0, 1'b1, 4'd2},
      {1'b0, 2'b00, 1'b0, 1'b1, 4'd4},
      {1'b0, 2'b00, 1'b0, 1'b1, 4'd6},
      {1'b0, 2'b00, 1'b0, 1'b1, 4'd8},
      {1'b0, 2'b00, 1'b0, 1'b1, 4'd0},
      {1'b0, 2'b00, 1'b1, 1'b0, 4'd1}
   };

   logic           clk = 1'b0;
   logic           rst_n;
   logic [N-1:0]   clk_a_drv, clk_b, ctr_rst;
   logic [2*N-1:0] chain_mode;
   logic [4*N-1:0] q_out;
   logic           cascade;
   logic [N-1:0]   clk_a;
   int             compared = 0;
   int             mismatched = 0;

   always #2.5 clk = ~clk;

   assign clk_a = {cascade ? q_out[3] : clk_a_drv[1], clk_a_drv[0]};

   dual_decade_counter #(.NUM_CTR(N), .SYNC_STAGES(SYNC)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .clk_a      (clk_a),
      .clk_b      (clk_b),
      .ctr_rst    (ctr_rst),
      .chain_mode (chain_mode),
      .q_out      (q_out)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic pulse(input int idx, input bit on_b);
      if (on_b) clk_b[idx] = 1'b0; else clk_a_drv[idx] = 1'b0;
      repeat (5) @(negedge clk);
      if (on_b) clk_b[idx] = 1'b1; else clk_a_drv[idx] = 1'b1;
      repeat (5) @(negedge clk);
   endtask

   task automatic clear_ctr(input int idx);
      ctr_rst[idx] = 1'b1;
      repeat (4) @(negedge clk);
      ctr_rst[idx] = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      #1_000_000;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      rst_n = 1'b0; clk_a_drv = '1; clk_b = '1; ctr_rst = '0;
      chain_mode = '0; cascade = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R8 reset state", q_out, 8'h00);

      // table walk on counter 0
      for (int k = 0; k < NV; k++) begin
         string tag;
         chain_mode[1:0] = VEC[k][7:6];
         if (VEC[k][8]) begin
            clear_ctr(0);
            tag = "R1 clear";
         end else begin
            if (VEC[k][5]) pulse(0, 1'b0);
            if (VEC[k][4]) pulse(0, 1'b1);
            case (VEC[k][7:6])
               2'b01:   tag = "R4 bcd";
               2'b10:   tag = "R5 biquinary";
               default: tag = VEC[k][5] ? "R2 qa toggle" : "R3 div5";
            endcase
         end
         check(tag, {4'd0, q_out[3:0]}, {4'd0, VEC[k][3:0]});
      end

      // latency and rising-edge immunity, independent mode
      chain_mode = '0;
      clear_ctr(0);
      clk_a_drv[0] = 1'b0;
      repeat (SYNC) @(negedge clk);
      check("R6 before update", {4'd0, q_out[3:0]}, 8'h00);
      @(negedge clk);
      check("R6 update edge", {4'd0, q_out[3:0]}, 8'h01);
      clk_a_drv[0] = 1'b1;
      repeat (6) @(negedge clk);
      check("R2 rising ignored", {4'd0, q_out[3:0]}, 8'h01);

      // reserved mode code acts as independent
      chain_mode[1:0] = 2'b11;
      pulse(0, 1'b1);
      check("R3 code 11", {4'd0, q_out[3:0]}, 8'h03);

      // asynchronous clear mid-count, counter 1 independent
      chain_mode = 4'b0001;
      clear_ctr(0);
      clear_ctr(1);
      pulse(0, 1'b0); pulse(0, 1'b0); pulse(0, 1'b0);
      pulse(1, 1'b1);
      check("R4 pre-clear", {4'd0, q_out[3:0]}, 8'h03);
      #1 ctr_rst[0] = 1'b1;
      #1 check("R1 immediate", {4'd0, q_out[3:0]}, 8'h00);
      check("R7 neighbour kept", {4'd0, q_out[7:4]}, 8'h02);
      pulse(0, 1'b0);
      check("R1 held", {4'd0, q_out[3:0]}, 8'h00);
      ctr_rst[0] = 1'b0;
      repeat (2) @(negedge clk);
      pulse(0, 1'b0);
      check("R1 restart", {4'd0, q_out[3:0]}, 8'h01);
      check("R7 neighbour unchanged", {4'd0, q_out[7:4]}, 8'h02);

      // divide by 100
      chain_mode = 4'b0101;
      cascade = 1'b1;
      ctr_rst = '1;
      repeat (6) @(negedge clk);
      ctr_rst = '0;
      repeat (2) @(negedge clk);
      check("R7 cascade start", q_out, 8'h00);
      for (int n = 1; n <= 100; n++) begin
         int m;
         m = n % 100;
         pulse(0, 1'b0);
         check("R7 divide by 100", q_out, {4'(m / 10), 4'(m % 10)});
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule